// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block steers a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) past three kinds of trouble. The first is an instruction that reads a register a load or a pop is still fetching from memory. The second is a conditional jump that was predicted taken but whose condition turns out false. The third is a return whose target is not known until it leaves the memory stage. Each cycle it looks at the operation codes and register IDs held in its own decode, execute, memory and write-back stage registers, and at the branch condition the execute stage produces. From these it derives, in combinational logic, a stall and a bubble request for each stage register.

The stage registers live inside the block. Each one loads its input, holds, or loads a nop word at the next rising edge, according to those requests. The fetch stage sits outside, so the block only reports whether fetch must hold. When several conditions arise in the same cycle, fixed priorities decide the outcome, so that no stage register is ever asked to stall and bubble at once.

Top module: `hazard_ctl_unit`

## Requirements
- R1: When execute holds a load (op 5) or a pop (op 11) whose memory destination equals decode source A or source B, stall_f=1, stall_d=1, bubble_e=1 and bubble_d=0 in that cycle; at the next edge decode keeps its instruction and execute becomes a nop (op 1).
- R2: When execute holds a conditional jump (op 7) and ex_cond=0, bubble_d=1, bubble_e=1 and stall_d=0; fetch is not stalled unless R3 also applies.
- R3: When a return (op 9) is in decode, execute or memory, stall_f=1; without a coinciding R1 condition, bubble_d=1 as well.
- R4: When the R1 and R3 conditions coincide, the R1 response wins: stall_f=1, stall_d=1, bubble_d=0, bubble_e=1.
- R5: When a mispredicted jump is in execute while a return is in decode, stall_f=1, bubble_d=1, bubble_e=1, stall_d=0.
- R6: Register ID 0xF marks an absent operand and never produces a match, even when the destination and the source are both 0xF.
- R7: Decode and execute stage registers load their input when neither stall nor bubble applies, hold on stall, and load the nop word (op 1, all register IDs 0xF) on bubble; the fetch input is not taken into decode while stall_f is high.
- R8: The memory and write-back stage registers always load the previous stage's content at each edge.
- R9: A synchronous active-high reset loads the nop word into all four stage registers, after which every control output is 0.
- R10: ctl_error is high if any stage register receives stall and bubble together; with these priorities it never rises.
- R11: With none of the R1, R2 or R3 conditions present, stall_f, stall_d, bubble_d and bubble_e are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| fet_op | input | 4 | Operation code of the instruction leaving fetch |
| fet_src_a | input | 4 | First source register ID of the fetched instruction (0xF = none) |
| fet_src_b | input | 4 | Second source register ID of the fetched instruction (0xF = none) |
| fet_dst_m | input | 4 | Memory destination register ID of the fetched instruction (0xF = none) |
| ex_cond | input | 1 | Condition outcome computed for the instruction in execute |
| stall_f | output | 1 | Fetch must hold its state at the next edge |
| stall_d | output | 1 | Decode stage register holds at the next edge |
| bubble_d | output | 1 | Decode stage register loads the nop word at the next edge |
| bubble_e | output | 1 | Execute stage register loads the nop word at the next edge |
| ctl_error | output | 1 | Stall and bubble requested together for one stage register |
| dec_op | output | 4 | Operation code held in the decode stage register |
| exe_op | output | 4 | Operation code held in the execute stage register |
| mem_op | output | 4 | Operation code held in the memory stage register |
| wb_op | output | 4 | Operation code held in the write-back stage register |

## Verification
The properties assume that fet_op takes only the defined operation codes, that absent operands are written as 0xF, and that ex_cond carries meaning only while execute holds a conditional jump. They also assume that the surrounding fetch logic may present any word while stall_f is high, because that word is discarded. The stimulus draws operation codes from the defined set, draws register IDs from a small pool that includes 0xF so that matches and the absent-operand case arise often, and drives ex_cond freely in every cycle. Directed sequences before the long sweep place each combined case (load with return, mispredict with return) in its exact stage alignment.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    localparam int OP_W    = 4;
    localparam int REG_W   = 4;
    localparam int NUM_STG = 4;
    localparam int STG_D   = 0;
    localparam int STG_E   = 1;
    localparam int STG_M   = 2;
    localparam int STG_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_HALT  = 4'h0,
        OP_NOP   = 4'h1,
        OP_MOVE  = 4'h2,
        OP_STORE = 4'h4,
        OP_LOAD  = 4'h5,
        OP_ALU   = 4'h6,
        OP_JCC   = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } op_e;

    localparam logic [REG_W-1:0] REG_NONE = '1;

    typedef struct packed {
        op_e              op;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic [REG_W-1:0] dst_m;
    } stage_t;

    localparam int STAGE_W = $bits(stage_t);

    localparam stage_t STAGE_NOP = '{op: OP_NOP, src_a: REG_NONE,
                                     src_b: REG_NONE, dst_m: REG_NONE};

    typedef struct packed {
        logic stall;
        logic bubble;
    } mode_t;

    localparam mode_t MODE_NORMAL = '{stall: 1'b0, bubble: 1'b0};

    // Operations that write a register with a value read from memory.
    function automatic logic writes_from_mem(input op_e op);
        return (op == OP_LOAD) || (op == OP_POP);
    endfunction

    // A destination matches a source only when it names a real register.
    function automatic logic reg_hit(input logic [REG_W-1:0] dst,
                                     input logic [REG_W-1:0] a,
                                     input logic [REG_W-1:0] b);
        return (dst != REG_NONE) && ((dst == a) || (dst == b));
    endfunction

endpackage

// File: rtl/hzc_stage_reg.sv
module hzc_stage_reg #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   NOP_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stall,
    input  logic         bubble,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst || bubble) begin
            q <= NOP_VAL;
        end else if (!stall) begin
            q <= d;
        end
    end

endmodule

// File: rtl/hzc_detect.sv
module hzc_detect
    import hzc_pkg::*;
(
    input  stage_t dec_s,
    input  stage_t exe_s,
    input  op_e    mem_op,
    input  logic   ex_cond,
    output logic   load_use,
    output logic   mispredict,
    output logic   ret_busy
);

    always_comb begin
        load_use   = writes_from_mem(exe_s.op) &&
                     reg_hit(exe_s.dst_m, dec_s.src_a, dec_s.src_b);
        mispredict = (exe_s.op == OP_JCC) && !ex_cond;
        ret_busy   = (dec_s.op == OP_RET) || (exe_s.op == OP_RET) ||
                     (mem_op == OP_RET);
    end

endmodule

// File: rtl/hzc_resolve.sv
module hzc_resolve
    import hzc_pkg::*;
(
    input  logic  load_use,
    input  logic  mispredict,
    input  logic  ret_busy,
    output logic  f_stall,
    output mode_t d_mode,
    output mode_t e_mode,
    output logic  conflict
);

    always_comb begin
        // Fetch holds for a load/use stall or while a return is in flight.
        f_stall       = load_use || ret_busy;
        // Load/use takes precedence over the return bubble in decode.
        d_mode.stall  = load_use;
        d_mode.bubble = mispredict || (ret_busy && !load_use);
        e_mode.stall  = 1'b0;
        e_mode.bubble = mispredict || load_use;
        conflict      = (d_mode.stall && d_mode.bubble) ||
                        (e_mode.stall && e_mode.bubble);
    end

endmodule

// File: rtl/hazard_ctl_unit.sv
module hazard_ctl_unit
    import hzc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] fet_op,
    input  logic [3:0] fet_src_a,
    input  logic [3:0] fet_src_b,
    input  logic [3:0] fet_dst_m,
    input  logic       ex_cond,
    output logic       stall_f,
    output logic       stall_d,
    output logic       bubble_d,
    output logic       bubble_e,
    output logic       ctl_error,
    output logic [3:0] dec_op,
    output logic [3:0] exe_op,
    output logic [3:0] mem_op,
    output logic [3:0] wb_op
);

    stage_t fetch_s;
    stage_t stg_d    [NUM_STG];
    stage_t stg_q    [NUM_STG];
    mode_t  stg_mode [NUM_STG];
    mode_t  d_mode;
    mode_t  e_mode;
    logic   load_use;
    logic   mispredict;
    logic   ret_busy;

    assign fetch_s = '{op: op_e'(fet_op), src_a: fet_src_a,
                       src_b: fet_src_b, dst_m: fet_dst_m};

    // Each stage register is fed by the stage before it.
    always_comb begin
        stg_d[0] = fetch_s;
        for (int i = 1; i < NUM_STG; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    // Only decode and execute take control; later stages always advance.
    always_comb begin
        for (int i = 0; i < NUM_STG; i++) begin
            stg_mode[i] = MODE_NORMAL;
        end
        stg_mode[STG_D] = d_mode;
        stg_mode[STG_E] = e_mode;
    end

    for (genvar g = 0; g < NUM_STG; g++) begin : g_stage
        logic [STAGE_W-1:0] q_vec;
        hzc_stage_reg #(
            .W       (STAGE_W),
            .NOP_VAL (STAGE_NOP)
        ) u_reg (
            .clk    (clk),
            .rst    (rst),
            .stall  (stg_mode[g].stall),
            .bubble (stg_mode[g].bubble),
            .d      (stg_d[g]),
            .q      (q_vec)
        );
        assign stg_q[g] = stage_t'(q_vec);
    end

    hzc_detect u_detect (
        .dec_s      (stg_q[STG_D]),
        .exe_s      (stg_q[STG_E]),
        .mem_op     (stg_q[STG_M].op),
        .ex_cond    (ex_cond),
        .load_use   (load_use),
        .mispredict (mispredict),
        .ret_busy   (ret_busy)
    );

    hzc_resolve u_resolve (
        .load_use   (load_use),
        .mispredict (mispredict),
        .ret_busy   (ret_busy),
        .f_stall    (stall_f),
        .d_mode     (d_mode),
        .e_mode     (e_mode),
        .conflict   (ctl_error)
    );

    assign stall_d  = d_mode.stall;
    assign bubble_d = d_mode.bubble;
    assign bubble_e = e_mode.bubble;
    assign dec_op   = stg_q[STG_D].op;
    assign exe_op   = stg_q[STG_E].op;
    assign mem_op   = stg_q[STG_M].op;
    assign wb_op    = stg_q[STG_W].op;

endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk
    import hzc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ex_cond,
    input logic       stall_f,
    input logic       stall_d,
    input logic       bubble_d,
    input logic       bubble_e,
    input logic       ctl_error,
    input logic [3:0] dec_op,
    input logic [3:0] exe_op,
    input logic [3:0] mem_op,
    input logic [3:0] wb_op
);

    // R3
    ret_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_op == OP_RET || exe_op == OP_RET || mem_op == OP_RET) |-> stall_f);

    // R2
    mispredict_chk: assert property (@(posedge clk) disable iff (rst)
        (exe_op == OP_JCC && !ex_cond) |-> (bubble_d && bubble_e && !stall_d));

    // R7
    dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall_d |=> $stable(dec_op));

    // R7
    exe_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        bubble_e |=> (exe_op == OP_NOP));

    // R7
    dec_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        bubble_d |=> (dec_op == OP_NOP));

    // R8
    mem_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mem_op == $past(exe_op)));

    // R8
    wb_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wb_op == $past(mem_op)));

    // R10
    no_conflict_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_error && !(stall_d && bubble_d));

    // R9
    reset_nop_chk: assert property (@(posedge clk)
        rst |=> (dec_op == OP_NOP && exe_op == OP_NOP &&
                 mem_op == OP_NOP && wb_op == OP_NOP));

endmodule

bind hazard_ctl_unit hazard_ctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ex_cond   (ex_cond),
    .stall_f   (stall_f),
    .stall_d   (stall_d),
    .bubble_d  (bubble_d),
    .bubble_e  (bubble_e),
    .ctl_error (ctl_error),
    .dec_op    (dec_op),
    .exe_op    (exe_op),
    .mem_op    (mem_op),
    .wb_op     (wb_op)
);

// File: tb/hazard_ctl_unit_tb.sv
`timescale 1ns/1ps
module hazard_ctl_unit_tb;
    import hzc_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] fet_op = 4'h1;
    logic [3:0] fet_src_a = 4'hF;
    logic [3:0] fet_src_b = 4'hF;
    logic [3:0] fet_dst_m = 4'hF;
    logic       ex_cond = 1'b0;
    logic       stall_f, stall_d, bubble_d, bubble_e, ctl_error;
    logic [3:0] dec_op, exe_op, mem_op, wb_op;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [31:0] seed = 32'h1F2E_3D4C;

    // Behavioural model of the stage contents, derived from the requirements.
    stage_t m_d, m_e, m_m, m_w;

    always #10 clk = ~clk;

    hazard_ctl_unit u_dut (
        .clk(clk), .rst(rst),
        .fet_op(fet_op), .fet_src_a(fet_src_a), .fet_src_b(fet_src_b),
        .fet_dst_m(fet_dst_m), .ex_cond(ex_cond),
        .stall_f(stall_f), .stall_d(stall_d), .bubble_d(bubble_d),
        .bubble_e(bubble_e), .ctl_error(ctl_error),
        .dec_op(dec_op), .exe_op(exe_op), .mem_op(mem_op), .wb_op(wb_op)
    );

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic stage_t mk(input op_e op, input logic [3:0] a,
                                  input logic [3:0] b, input logic [3:0] dm);
        return '{op: op, src_a: a, src_b: b, dst_m: dm};
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // One cycle: drive at the falling edge, check, then advance the model.
    task automatic step(input stage_t inst, input logic cond);
        logic lu, mp, rt, e_sf, e_sd, e_bd, e_be;
        string tag;
        @(negedge clk);
        fet_op    = inst.op;
        fet_src_a = inst.src_a;
        fet_src_b = inst.src_b;
        fet_dst_m = inst.dst_m;
        ex_cond   = cond;
        #1;
        lu = (m_e.op == OP_LOAD || m_e.op == OP_POP) && m_e.dst_m != 4'hF &&
             (m_e.dst_m == m_d.src_a || m_e.dst_m == m_d.src_b);
        mp = (m_e.op == OP_JCC) && !cond;
        rt = (m_d.op == OP_RET) || (m_e.op == OP_RET) || (m_m.op == OP_RET);
        e_sf = lu || rt;
        e_sd = lu;
        e_bd = mp || (rt && !lu);
        e_be = mp || lu;
        if (lu && rt)                      tag = "R4";
        else if (mp && m_d.op == OP_RET)   tag = "R5";
        else if (lu)                       tag = "R1";
        else if (mp)                       tag = "R2";
        else if (rt)                       tag = "R3";
        else if ((m_e.op == OP_LOAD || m_e.op == OP_POP) && m_e.dst_m == 4'hF)
                                           tag = "R6";
        else                               tag = "R11";
        chk("R7", "dec_op", 8'(dec_op), 8'(m_d.op));
        chk("R7", "exe_op", 8'(exe_op), 8'(m_e.op));
        chk("R8", "mem_op", 8'(mem_op), 8'(m_m.op));
        chk("R8", "wb_op",  8'(wb_op),  8'(m_w.op));
        chk(tag, "stall_f",  8'(stall_f),  8'(e_sf));
        chk(tag, "stall_d",  8'(stall_d),  8'(e_sd));
        chk(tag, "bubble_d", 8'(bubble_d), 8'(e_bd));
        chk(tag, "bubble_e", 8'(bubble_e), 8'(e_be));
        chk("R10", "ctl_error", 8'(ctl_error), 8'h00);
        m_w = m_m;
        m_m = m_e;
        m_e = e_be ? STAGE_NOP : m_d;
        if (e_bd)       m_d = STAGE_NOP;
        else if (!e_sd) m_d = inst;
    endtask

    task automatic nops(input int n, input logic cond);
        for (int i = 0; i < n; i++) step(STAGE_NOP, cond);
    endtask

    function automatic op_e pick_op(input logic [2:0] k);
        case (k)
            3'd0: return OP_NOP;
            3'd1: return OP_ALU;
            3'd2: return OP_LOAD;
            3'd3: return OP_POP;
            3'd4: return OP_JCC;
            3'd5: return OP_RET;
            3'd6: return OP_STORE;
            default: return OP_MOVE;
        endcase
    endfunction

    function automatic logic [3:0] pick_reg(input logic [1:0] k);
        return (k == 2'd3) ? 4'hF : {2'b00, k};
    endfunction

    initial begin
        m_d = STAGE_NOP; m_e = STAGE_NOP; m_m = STAGE_NOP; m_w = STAGE_NOP;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9", "dec_op", 8'(dec_op), 8'(OP_NOP));
        chk("R9", "exe_op", 8'(exe_op), 8'(OP_NOP));
        chk("R9", "mem_op", 8'(mem_op), 8'(OP_NOP));
        chk("R9", "wb_op",  8'(wb_op),  8'(OP_NOP));
        chk("R9", "controls", 8'({stall_f, stall_d, bubble_d, bubble_e}), 8'h00);
        rst = 1'b0;

        // R11 and R7: plain flow
        step(mk(OP_ALU, 4'h1, 4'h2, 4'hF), 1'b1);
        step(mk(OP_MOVE, 4'h0, 4'hF, 4'hF), 1'b1);
        step(mk(OP_STORE, 4'h1, 4'h2, 4'hF), 1'b1);
        nops(3, 1'b1);

        // R1: load then use on source A; pop then use on source B
        step(mk(OP_LOAD, 4'h0, 4'hF, 4'h1), 1'b1);
        step(mk(OP_ALU, 4'h1, 4'h2, 4'hF), 1'b1);
        nops(4, 1'b1);
        step(mk(OP_POP, 4'h3, 4'hF, 4'h2), 1'b1);
        step(mk(OP_ALU, 4'h0, 4'h2, 4'hF), 1'b1);
        nops(4, 1'b1);

        // R6: absent operands never match
        step(mk(OP_LOAD, 4'h0, 4'hF, 4'hF), 1'b1);
        step(mk(OP_ALU, 4'hF, 4'hF, 4'hF), 1'b1);
        nops(3, 1'b1);

        // R2: not-taken jump, then a taken one
        step(mk(OP_JCC, 4'hF, 4'hF, 4'hF), 1'b0);
        step(mk(OP_ALU, 4'h1, 4'h2, 4'hF), 1'b0);
        step(mk(OP_ALU, 4'h0, 4'h1, 4'hF), 1'b0);
        nops(3, 1'b0);
        step(mk(OP_JCC, 4'hF, 4'hF, 4'hF), 1'b1);
        step(mk(OP_ALU, 4'h1, 4'h2, 4'hF), 1'b1);
        step(mk(OP_ALU, 4'h0, 4'h1, 4'hF), 1'b1);
        nops(3, 1'b1);

        // R3: return travelling alone
        step(mk(OP_RET, 4'h4, 4'h4, 4'hF), 1'b1);
        nops(6, 1'b1);

        // R5: mispredicted jump with a return right behind it
        step(mk(OP_JCC, 4'hF, 4'hF, 4'hF), 1'b0);
        step(mk(OP_RET, 4'h4, 4'h4, 4'hF), 1'b0);
        nops(5, 1'b0);

        // R4: load of the stack register followed by a return
        step(mk(OP_LOAD, 4'h0, 4'hF, 4'h4), 1'b1);
        step(mk(OP_RET, 4'h4, 4'h4, 4'hF), 1'b1);
        nops(6, 1'b1);

        // Sweep over a small operand pool (includes 0xF) and all conditions
        for (int n = 0; n < 4000; n++) begin
            stage_t ins;
            seed = next_rand(seed);
            ins = mk(pick_op(seed[2:0]), pick_reg(seed[4:3]),
                     pick_reg(seed[6:5]), pick_reg(seed[8:7]));
            step(ins, seed[9]);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule